// File: doc/BRIEF.md
# Aliased Control Register Bank

This block is an 8-bit register bank that sits behind the control interface of a transceiver-style device. Each writable register answers at three consecutive addresses. The lowest address loads the bus data. The next one ORs the data into the register. The third treats the data as a mask and clears the bits it marks. Software can therefore change single bits without first reading the register back.

The immediate space uses 6-bit addresses and holds four fixed identification bytes, three read-only status bytes that come from inputs, a scratch register, a power-control register at the top of the space, and several holes. One immediate address is an escape. An access to it takes a separate 8-bit extended address from its own field. The lower quarter of that extended space is a mirror of the immediate set, and the rest of it reads as zero.

The bus is a single-cycle synchronous port. A write takes effect at the clock edge where the strobe is sampled. Read data is registered and appears one cycle after the read strobe.

Top module: `ctrl_regbank`

## Requirements
- R1: After reset every writable register reads 00h, and immediate addresses 00h, 01h, 02h and 03h read the identification parameters ID_VEND_LO, ID_VEND_HI, ID_PROD_LO and ID_PROD_HI.
- R2: A write at a register's base address replaces all 8 bits with wdata.
- R3: A write at base+1 ORs wdata into the register.
- R4: A write at base+2 clears every register bit whose wdata bit is 1 and leaves the other bits unchanged.
- R5: The writable registers have bases 04h, 07h, 0Ah, 0Dh, 10h, 16h (scratch) and 3Dh (power control). A read at any of the three aliases returns the current value.
- R6: Writes to 00h–03h, 13h, 14h and 15h are ignored. Reads of 13h, 14h and 15h return the inputs stat_a, stat_b and stat_c.
- R7: Immediate addresses 19h–2Eh and 30h–3Ch read 00h, and writes to them change no register.
- R8: When addr is 2Fh, the access uses ext_addr. Values 00h–3Fh act exactly like the same immediate address, with the same single-cycle timing.
- R9: Through the escape, ext_addr 2Fh and 40h–FFh read 00h, and writes there change no register.
- R10: rdata is loaded at the clock edge where rd is high and holds while rd is low. If rd and wr are high in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Immediate address; 2Fh selects the extended space |
| ext_addr | input | 8 | Extended address, used when addr is 2Fh |
| wdata | input | 8 | Write data or mask |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| stat_a | input | 8 | Value returned at 13h |
| stat_b | input | 8 | Value returned at 14h |
| stat_c | input | 8 | Value returned at 15h |
| rdata | output | 8 | Registered read data |

## Verification
The bench targets the alias arithmetic in three ways. It checks the set alias on a register that already holds bits. It uses a clear mask that overlaps only some of the stored bits. It reads every register through its third alias, where an off-by-one decode would write or read the wrong neighbour. It writes through the escape and reads back through the immediate address. It also probes the escape's own number, and the extended addresses just above the mirrored range and at the very top, which a design that forgot to check the upper address bits would alias onto real registers. Writes to identification, status and reserved addresses are followed by a readback of every writable register, so that a write which leaks into the wrong register shows up. A read in the same cycle as a write exposes a design that forwards the new data.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int ADDR_W   = 6;
  localparam int EXT_W    = 8;
  localparam int DATA_W   = 8;
  localparam int NUM_TRIP = 7;
  localparam logic [ADDR_W-1:0] ESC_ADDR = 6'h2F;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  // base address of each write/set/clear triplet
  function automatic logic [ADDR_W-1:0] trip_base(input int idx);
    case (idx)
      0:       return 6'h04;
      1:       return 6'h07;
      2:       return 6'h0A;
      3:       return 6'h0D;
      4:       return 6'h10;
      5:       return 6'h16;
      default: return 6'h3D;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] apply_op(input op_e op,
                                                 input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] wd);
    case (op)
      OP_LOAD: return wd;
      OP_SET:  return cur | wd;
      OP_CLR:  return cur & ~wd;
      default: return cur;
    endcase
  endfunction

  function automatic logic addr_is_hole(input logic [ADDR_W-1:0] a);
    return ((a >= 6'h19) && (a <= 6'h2F)) || ((a >= 6'h30) && (a <= 6'h3C));
  endfunction
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [EXT_W-1:0]    ext_addr,
  output logic [ADDR_W-1:0]   eff_addr,
  output logic                eff_valid,
  output logic                is_hole,
  output logic [NUM_TRIP-1:0] trip_hit,
  output op_e                 trip_op
);
  localparam logic [EXT_W-1:0] EXT_MIRROR_LIM = EXT_W'(1 << ADDR_W);

  logic escape;

  always_comb begin
    escape = (addr == ESC_ADDR);
    if (escape) begin
      eff_addr  = ext_addr[ADDR_W-1:0];
      eff_valid = (ext_addr < EXT_MIRROR_LIM) && (ext_addr[ADDR_W-1:0] != ESC_ADDR);
    end else begin
      eff_addr  = addr;
      eff_valid = 1'b1;
    end
    is_hole = !eff_valid || addr_is_hole(eff_addr);
  end

  always_comb begin
    trip_hit = '0;
    trip_op  = OP_NONE;
    for (int i = 0; i < NUM_TRIP; i++) begin
      if (eff_valid && (eff_addr >= trip_base(i)) && (eff_addr <= trip_base(i) + 6'd2)) begin
        trip_hit[i] = 1'b1;
        trip_op     = op_e'(2'(eff_addr - trip_base(i)));
      end
    end
  end

  // a hole never selects a register (R7, R9)
  p_hole_no_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_hole |-> (trip_hit == '0));
  p_hit_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trip_hit));
endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              hit,
  input  op_e               op,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);
  logic upd;
  assign upd = wr && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= apply_op(op, q, wd);
  end

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == OP_LOAD) |=> q == $past(wd));
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == OP_SET) |=> ((q & $past(wd)) == $past(wd)) && ((q & $past(q)) == $past(q)));
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op == OP_CLR) |=> ((q & $past(wd)) == '0) && ((q | $past(wd)) == ($past(q) | $past(wd))));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q));
endmodule

// File: rtl/regbank_readmux.sv
module regbank_readmux
  import regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_VEND_LO = 8'h11,
  parameter logic [DATA_W-1:0] ID_VEND_HI = 8'h22,
  parameter logic [DATA_W-1:0] ID_PROD_LO = 8'h33,
  parameter logic [DATA_W-1:0] ID_PROD_HI = 8'h44
) (
  input  logic [ADDR_W-1:0]                eff_addr,
  input  logic                             eff_valid,
  input  logic [NUM_TRIP-1:0]              trip_hit,
  input  logic [NUM_TRIP-1:0][DATA_W-1:0]  trip_q,
  input  logic [DATA_W-1:0]                stat_a,
  input  logic [DATA_W-1:0]                stat_b,
  input  logic [DATA_W-1:0]                stat_c,
  output logic [DATA_W-1:0]                rd_val
);
  always_comb begin
    rd_val = '0;
    if (eff_valid) begin
      case (eff_addr)
        6'h00:   rd_val = ID_VEND_LO;
        6'h01:   rd_val = ID_VEND_HI;
        6'h02:   rd_val = ID_PROD_LO;
        6'h03:   rd_val = ID_PROD_HI;
        6'h13:   rd_val = stat_a;
        6'h14:   rd_val = stat_b;
        6'h15:   rd_val = stat_c;
        default: begin
          for (int i = 0; i < NUM_TRIP; i++)
            if (trip_hit[i]) rd_val = rd_val | trip_q[i];
        end
      endcase
    end
  end
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
  import regbank_pkg::*;
#(
  parameter logic [7:0] ID_VEND_LO = 8'h11,
  parameter logic [7:0] ID_VEND_HI = 8'h22,
  parameter logic [7:0] ID_PROD_LO = 8'h33,
  parameter logic [7:0] ID_PROD_HI = 8'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] addr,
  input  logic [7:0] ext_addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] stat_a,
  input  logic [7:0] stat_b,
  input  logic [7:0] stat_c,
  output logic [7:0] rdata
);
  logic [ADDR_W-1:0]               eff_addr;
  logic                            eff_valid;
  logic                            is_hole;
  logic [NUM_TRIP-1:0]             trip_hit;
  op_e                             trip_op;
  logic [NUM_TRIP-1:0][DATA_W-1:0] trip_q;
  logic [DATA_W-1:0]               rd_val;

  regbank_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ext_addr(ext_addr),
    .eff_addr(eff_addr), .eff_valid(eff_valid), .is_hole(is_hole),
    .trip_hit(trip_hit), .trip_op(trip_op)
  );

  for (genvar g = 0; g < NUM_TRIP; g++) begin : g_cell
    regbank_cell u_cell (
      .clk(clk), .rst_n(rst_n), .wr(wr), .hit(trip_hit[g]),
      .op(trip_op), .wd(wdata), .q(trip_q[g])
    );
  end

  regbank_readmux #(
    .ID_VEND_LO(ID_VEND_LO), .ID_VEND_HI(ID_VEND_HI),
    .ID_PROD_LO(ID_PROD_LO), .ID_PROD_HI(ID_PROD_HI)
  ) u_rmux (
    .eff_addr(eff_addr), .eff_valid(eff_valid), .trip_hit(trip_hit),
    .trip_q(trip_q), .stat_a(stat_a), .stat_b(stat_b), .stat_c(stat_c),
    .rd_val(rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_val;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  p_hole_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && is_hole) |=> rdata == '0);
  p_id_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && eff_valid && eff_addr == 6'h00) |=> rdata == ID_VEND_LO);
endmodule

// File: tb/sim_ctrl_regbank.sv
`timescale 1ns/1ps
module sim_ctrl_regbank;
  localparam logic [7:0] VL = 8'hC1, VH = 8'h5E, PL = 8'h7A, PH = 8'h09;

  logic clk = 0, rst_n = 0;
  logic [5:0] addr = 0;
  logic [7:0] ext_addr = 0, wdata = 0, stat_a = 8'h3C, stat_b = 8'h81, stat_c = 8'hE7;
  logic wr = 0, rd = 0;
  logic [7:0] rdata;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ctrl_regbank #(.ID_VEND_LO(VL), .ID_VEND_HI(VH), .ID_PROD_LO(PL), .ID_PROD_HI(PH)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ext_addr(ext_addr), .wdata(wdata),
    .wr(wr), .rd(rd), .stat_a(stat_a), .stat_b(stat_b), .stat_c(stat_c), .rdata(rdata));

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 0;

  // monitor: read captured at posedge, compared at following negedge
  always @(posedge clk) pend <= rd;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr_op(input logic [5:0] a, input logic [7:0] ea, input logic [7:0] d);
    @(negedge clk); addr = a; ext_addr = ea; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] ea, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; ext_addr = ea; rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 0;
  endtask

  task automatic rw_chk(input logic [5:0] a, input logic [7:0] d, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; wdata = d; wr = 1; rd = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); wr = 0; rd = 0;
  endtask

  // bench's own list of triplet bases
  function automatic logic [5:0] base_of(input int i);
    logic [5:0] b [7] = '{6'h04, 6'h07, 6'h0A, 6'h0D, 6'h10, 6'h16, 6'h3D};
    return b[i];
  endfunction

  logic [7:0] model [7];

  task automatic check_all(input string t);
    for (int i = 0; i < 7; i++) rd_chk(base_of(i) + 6'd2, 8'h00, model[i], t);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd_chk(6'h00, 0, VL, "R1 vend lo");
    rd_chk(6'h01, 0, VH, "R1 vend hi");
    rd_chk(6'h02, 0, PL, "R1 prod lo");
    rd_chk(6'h03, 0, PH, "R1 prod hi");
    for (int i = 0; i < 7; i++) model[i] = 8'h00;
    check_all("R1 writable reset");

    // R2/R3/R4 on register 04h, R5 aliases
    wr_op(6'h04, 0, 8'hA5); model[0] = 8'hA5;
    rd_chk(6'h04, 0, 8'hA5, "R2 load");
    rd_chk(6'h05, 0, 8'hA5, "R5 alias+1");
    wr_op(6'h05, 0, 8'h0F); model[0] = 8'hAF;
    rd_chk(6'h04, 0, 8'hAF, "R3 set");
    wr_op(6'h06, 0, 8'hA3); model[0] = 8'h0C;
    rd_chk(6'h06, 0, 8'h0C, "R4 clear");

    // R5 each triplet distinct value via load, set, clear
    for (int i = 0; i < 7; i++) begin
      wr_op(base_of(i), 0, 8'(i * 8'h13 + 8'h21));
      wr_op(base_of(i) + 6'd1, 0, 8'h80);
      wr_op(base_of(i) + 6'd2, 0, 8'h01);
      model[i] = (8'(i * 8'h13 + 8'h21) | 8'h80) & ~8'h01;
    end
    check_all("R5 all triplets");

    // R6 read-only
    wr_op(6'h00, 0, 8'hFF); wr_op(6'h03, 0, 8'hFF);
    wr_op(6'h13, 0, 8'hFF); wr_op(6'h15, 0, 8'h00);
    rd_chk(6'h00, 0, VL, "R6 id unchanged");
    rd_chk(6'h13, 0, 8'h3C, "R6 stat a");
    rd_chk(6'h14, 0, 8'h81, "R6 stat b");
    @(negedge clk); stat_c = 8'h5A;
    rd_chk(6'h15, 0, 8'h5A, "R6 stat c");
    check_all("R6 no leak");

    // R7 holes
    wr_op(6'h19, 0, 8'hFF); wr_op(6'h2E, 0, 8'hFF);
    wr_op(6'h30, 0, 8'hFF); wr_op(6'h3C, 0, 8'hFF);
    rd_chk(6'h19, 0, 8'h00, "R7 hole 19");
    rd_chk(6'h2E, 0, 8'h00, "R7 hole 2E");
    rd_chk(6'h30, 0, 8'h00, "R7 hole 30");
    rd_chk(6'h3C, 0, 8'h00, "R7 hole 3C");
    check_all("R7 no leak");

    // R8 escape mirror
    wr_op(6'h2F, 8'h07, 8'h55); model[1] = 8'h55;
    rd_chk(6'h07, 0, 8'h55, "R8 ext write");
    wr_op(6'h2F, 8'h3E, 8'h0A); model[6] = model[6] | 8'h0A;
    rd_chk(6'h2F, 8'h3D, model[6], "R8 ext set");
    rd_chk(6'h2F, 8'h01, VH, "R8 ext id");
    rd_chk(6'h2F, 8'h14, 8'h81, "R8 ext stat");

    // R9 extended holes
    wr_op(6'h2F, 8'h44, 8'hFF); wr_op(6'h2F, 8'hD6, 8'hFF);
    wr_op(6'h2F, 8'h2F, 8'hFF); wr_op(6'h2F, 8'hFF, 8'hFF);
    rd_chk(6'h2F, 8'h40, 8'h00, "R9 ext 40");
    rd_chk(6'h2F, 8'hC4, 8'h00, "R9 ext C4 alias");
    rd_chk(6'h2F, 8'hFF, 8'h00, "R9 ext FF");
    rd_chk(6'h2F, 8'h2F, 8'h00, "R9 ext 2F");
    check_all("R9 no leak");

    // R10 same-cycle read returns old; back-to-back read sees new; hold
    rw_chk(6'h16, 8'h99, model[5], "R10 rd+wr old value");
    model[5] = 8'h99;
    rd_chk(6'h17, 0, 8'h99, "R10 new value");
    @(negedge clk); addr = 6'h00;
    @(negedge clk); @(negedge clk);
    checks++;
    if (rdata !== 8'h99) begin
      errors++;
      $display("FAIL R10 hold: got %02h expected %02h", rdata, 8'h99);
    end

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule